// File: doc/BRIEF.md
# Queued Asynchronous Serial Transmitter

This block turns bytes written by the surrounding logic into framed asynchronous serial characters on one output wire. Each character has one start bit, eight data bits and one stop bit, with no parity. A write strobe with a byte pushes that byte into an internal queue, so a caller can hand over a burst of bytes on consecutive cycles and move on. The queue is then drained in the background at the line rate.

The bit clock comes from a phase accumulator. It adds a fixed increment every system clock, and its carry out gives a one-cycle baud strobe. This lets the block reach a non-integer ratio between clock and baud rate without a PLL. The default is a 20-bit accumulator with an increment of 6036, which gives about 115200 baud from a 20 MHz clock. The state machine advances only on that strobe. Whenever the line is idle and no start is already pending, the block moves the oldest queued byte into a holding register, independent of the strobe.

Top module: `uart_tx_queue`

## Requirements
- R1: Reset drives `txd` high, empties the queue, clears the holding register's pending start, and leaves `busy` and `full` low. Nothing queued before reset is ever sent.
- R2: A character is a low start bit, then eight data bits with bit 0 sent first and bit 7 last, then a high stop bit. The line is high while idle.
- R3: One bit lasts 2^ACC_W/INC clocks, and every line edge lies within one clock of its ideal position. For byte 0x00, the rise into the stop bit comes 9 bit periods after the falling start edge. The state changes only on strobe cycles.
- R4: Queued bytes go out in the order they were written. When bytes are waiting, consecutive start edges are 11 bit periods apart: a 10-bit character followed by one idle bit period.
- R5: The queue holds 2^QA_W bytes (16 by default), plus one byte in the holding register. `full` is high exactly when the queue holds 2^QA_W bytes. So when 17 bytes are written back to back into an idle block, all 17 are accepted and `full` ends high.
- R6: A write while `full` is high is ignored and that byte is never sent. `dropped` is high for exactly the one cycle after such a write.
- R7: `busy` is high while a character is on the line, while a start is pending, or while the queue is not empty. Otherwise it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| wr_data | input | 8 | Byte to queue |
| full | output | 1 | Queue has no free entry |
| dropped | output | 1 | One-cycle pulse after a write that was refused |
| busy | output | 1 | Transmitter or queue still has work |
| txd | output | 1 | Serial line, idle high |

## Verification
The bench decodes the line at the ideal bit period and goes after the timing corners. A 0x00 character exposes a stop bit that is early or late by a strobe. Back-to-back characters show whether the idle bit between frames is missing or doubled. A 17-byte burst tests the point where the holding register and the queue are both full. Here an off-by-one full flag would either refuse the 17th byte or accept an 18th, and a broken pointer would reorder the output. A reset in the middle of a frame must silence the line at once and discard the queued bytes; a design that kept its pointers would keep sending them.

// File: rtl/uart_tx_queue.sv
module uart_tx_queue #(
  parameter int ACC_W = 20,
  parameter int INC   = 6036,
  parameter int QA_W  = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic       full,
  output logic       dropped,
  output logic       busy,
  output logic       txd
);
  localparam int QDEPTH = 1 << QA_W;
  localparam logic [1:0] S_IDLE = 2'd0, S_START = 2'd1, S_DATA = 2'd2, S_STOP = 2'd3;

  logic [ACC_W-1:0] acc;
  logic             stb;
  logic [7:0]       mem [QDEPTH];
  logic [QA_W-1:0]  wptr, rptr;
  logic [QA_W:0]    count;
  logic [7:0]       hold;
  logic             pend;
  logic [1:0]       state;
  logic [2:0]       bidx;
  logic             push, pop;

  assign full = (count == (QA_W+1)'(QDEPTH));
  assign push = wr_en && !full;
  assign pop  = (state == S_IDLE) && !pend && (count != '0);
  assign busy = (state != S_IDLE) || pend || (count != '0);

  always_ff @(posedge clk) begin
    if (rst) {stb, acc} <= '0;
    else     {stb, acc} <= {1'b0, acc} + (ACC_W+1)'(INC);
  end

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= wr_data;
    if (pop)  hold <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr    <= '0;
      rptr    <= '0;
      count   <= '0;
      dropped <= 1'b0;
    end else begin
      dropped <= wr_en && full;
      if (push) wptr <= wptr + 1'b1;
      if (pop)  rptr <= rptr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE;
      bidx  <= '0;
      pend  <= 1'b0;
    end else begin
      if (pop) pend <= 1'b1;
      if (stb) begin
        case (state)
          S_IDLE:  if (pend) state <= S_START;
          S_START: begin
            state <= S_DATA;
            bidx  <= '0;
            pend  <= 1'b0;
          end
          S_DATA:  begin
            if (bidx == 3'd7) state <= S_STOP;
            else              bidx  <= bidx + 1'b1;
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) txd <= 1'b1;
    else begin
      case (state)
        S_START: txd <= 1'b0;
        S_DATA:  txd <= hold[bidx];
        default: txd <= 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/uart_tx_queue_chk.sv
module uart_tx_queue_chk #(
  parameter int QA_W = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            wr_en,
  input logic            full,
  input logic            dropped,
  input logic            busy,
  input logic            txd,
  input logic            stb,
  input logic            pend,
  input logic [1:0]      state,
  input logic [QA_W:0]   count
);
  p_state_on_strobe_r3: assert property (@(posedge clk) disable iff (rst)
    !stb |=> $stable(state));
  p_start_low_r2: assert property (@(posedge clk) disable iff (rst)
    (state == 2'd1) |=> !txd);
  p_idle_high_r2: assert property (@(posedge clk) disable iff (rst)
    (state == 2'd0 || state == 2'd3) |=> txd);
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
    count <= (QA_W+1)'(1 << QA_W));
  p_drop_flag_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && full) |=> dropped);
  p_drop_stable_r6: assert property (@(posedge clk) disable iff (rst)
    full |=> (count == $past(count) || count == $past(count) - 1'b1));
  p_busy_r7: assert property (@(posedge clk) disable iff (rst)
    (state != 2'd0 || pend || count != '0) |-> busy);
endmodule

bind uart_tx_queue uart_tx_queue_chk #(.QA_W(QA_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .full(full), .dropped(dropped),
  .busy(busy), .txd(txd), .stb(stb), .pend(pend), .state(state), .count(count)
);

// File: tb/tb_uart_tx_queue.sv
module tb_uart_tx_queue;
  localparam int ACC_W = 20;
  localparam int INC   = 6036;
  localparam real P    = (2.0 ** ACC_W) / INC;

  logic clk = 0, rst = 1, wr_en = 0;
  logic [7:0] wr_data = '0;
  logic full, dropped, busy, txd;

  uart_tx_queue #(.ACC_W(ACC_W), .INC(INC), .QA_W(4)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .full(full), .dropped(dropped), .busy(busy), .txd(txd));

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, fails = 0;
  task automatic chk(input string req, input bit ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // line decoder
  logic [7:0] rx_byte [64];
  int rx_start [64];
  int rx_rise [64];
  bit rx_stop_ok [64];
  int rx_cnt = 0, falls = 0;
  bit mute = 0;
  initial begin
    logic prev;
    prev = 1;
    forever begin
      @(negedge clk);
      if (prev && !txd) begin
        int t0, rise;
        logic [7:0] b;
        logic last;
        t0 = cyc; rise = -1; last = 0; falls++;
        for (int i = 0; i < 9; i++) begin
          int tgt;
          tgt = t0 + int'((1.5 + i) * P);
          while (cyc < tgt) begin
            @(negedge clk);
            if (!last && txd && rise < 0) rise = cyc - t0;
            last = txd;
          end
          if (i < 8) b[i] = txd;
          else if (!mute) begin
            rx_byte[rx_cnt] = b; rx_start[rx_cnt] = t0;
            rx_rise[rx_cnt] = rise; rx_stop_ok[rx_cnt] = txd;
            rx_cnt++;
          end
        end
      end
      prev = txd;
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put(input logic [7:0] b);
    @(negedge clk); wr_en = 1; wr_data = b;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic wait_rx(input int n);
    while (rx_cnt < n) @(negedge clk);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 txd high", txd == 1, txd, 1);
    chk("R1 busy low", busy == 0, busy, 0);
    chk("R1 full low", full == 0, full, 0);
    chk("R6 dropped low", dropped == 0, dropped, 0);
  endtask

  task automatic t_single;
    int base;
    base = rx_cnt;
    put(8'hA5);
    chk("R7 busy after write", busy == 1, busy, 1);
    wait_rx(base + 1);
    chk("R2 byte A5", rx_byte[base] == 8'hA5, rx_byte[base], 8'hA5);
    chk("R2 stop high", rx_stop_ok[base], rx_stop_ok[base], 1);
    chk("R7 busy in stop", busy == 1, busy, 1);
    wait_cyc(int'(2 * P));
    chk("R7 busy low after frame", busy == 0, busy, 0);
  endtask

  task automatic t_zero_timing;
    int base, d;
    real e;
    base = rx_cnt;
    put(8'h00);
    wait_rx(base + 1);
    chk("R2 byte 00", rx_byte[base] == 8'h00, rx_byte[base], 0);
    d = rx_rise[base];
    e = 9.0 * P;
    chk("R3 stop edge at 9 periods", (d >= e - 1.0) && (d <= e + 1.0), d, int'(e));
    wait_cyc(int'(2 * P));
  endtask

  task automatic t_burst;
    int base, d;
    real e;
    bit ok;
    base = rx_cnt;
    for (int i = 0; i < 17; i++) begin
      @(negedge clk); wr_en = 1; wr_data = 8'(i * 29 + 3);
    end
    @(negedge clk); wr_en = 0;
    chk("R5 full after 17 writes", full == 1, full, 1);
    wr_en = 1; wr_data = 8'hEE;
    @(negedge clk); wr_en = 0;
    chk("R6 dropped pulse", dropped == 1, dropped, 1);
    @(negedge clk);
    chk("R6 dropped one cycle", dropped == 0, dropped, 0);
    wait_rx(base + 17);
    ok = 1;
    for (int i = 0; i < 17; i++)
      if (rx_byte[base + i] !== 8'(i * 29 + 3)) begin
        ok = 0;
        chk("R4 order", 0, rx_byte[base + i], i * 29 + 3);
      end
    chk("R4 all 17 in order", ok, ok, 1);
    e = 11.0 * P;
    ok = 1;
    for (int i = 1; i < 17; i++) begin
      d = rx_start[base + i] - rx_start[base + i - 1];
      if (d < e - 1.0 || d > e + 1.0) begin
        ok = 0;
        chk("R4 start spacing", 0, d, int'(e));
      end
    end
    chk("R3 R4 spacing within one clock", ok, ok, 1);
    wait_cyc(int'(3 * P));
    chk("R6 dropped byte never sent", rx_cnt == base + 17, rx_cnt - base, 17);
    chk("R7 busy low after burst", busy == 0, busy, 0);
  endtask

  task automatic t_reset_mid;
    int f0, base;
    mute = 1;
    put(8'h11); put(8'h22); put(8'h33);
    wait_cyc(int'(3 * P));
    @(negedge clk); rst = 1;
    @(negedge clk);
    chk("R1 txd high in reset", txd == 1, txd, 1);
    @(negedge clk); rst = 0;
    @(negedge clk);
    chk("R1 busy low after reset", busy == 0, busy, 0);
    f0 = falls;
    wait_cyc(int'(15 * P));
    chk("R1 queue discarded", falls == f0, falls - f0, 0);
    mute = 0;
    base = rx_cnt;
    put(8'h3C);
    wait_rx(base + 1);
    wait_cyc(int'(12 * P));
    chk("R1 only new byte sent", rx_cnt == base + 1 && rx_byte[base] == 8'h3C,
        rx_byte[base], 8'h3C);
  endtask

  initial begin
    wait_cyc(4);
    rst = 0;
    t_reset();
    t_single();
    t_zero_timing();
    t_burst();
    t_reset_mid();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    wait (cyc >= 150000);
    checks++; fails++;
    $display("FAIL watchdog: actual %0d expected below %0d", cyc, 150000);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule